// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt requests from a small, parameterized set of sources and turns them into a single vectored request for a simple processor core. Each source input passes through a two-flop synchronizer. It is then examined by a per-source trigger detector. The sensitivity of each detector is selectable: rising edge, falling edge, either edge, high level or low level. A detected trigger latches a sticky pending flag, whether or not the source is masked, so software may poll it. Software clears a flag by writing a one to it.

Every source carries an individual enable and a priority bit. A global enable gates delivery as a whole. Among the deliverable sources, high priority wins. The block raises a request with a fixed vector address for the winning level and reports the lowest-numbered pending source of that level. The core acknowledges on handler entry and pulses a return line on handler exit. A two-entry level stack records which handlers are active. A high-priority handler may preempt a low one. Nothing of the same or a lower level is delivered until the matching return.

Top module: `irq_ctrl`

## Requirements
- R1: A source's pending flag is set whenever its trigger condition occurs, regardless of its own enable bit or the global enable.
- R2: While the global enable is low, the request output stays low whatever flags are pending.
- R3: A source whose enable bit is low is never delivered, and it is not reported on the source-index output.
- R4: A delivered high-priority request (priority bit 1) presents vector 0x08; a delivered low-priority request (priority bit 0) presents vector 0x18.
- R5: A pending, enabled high-priority source raises the request while only a low-priority handler is active. A low-priority source never raises it while a high-priority handler is active.
- R6: A flag set while its source was masked raises the request in the cycle in which the mask is lifted. If software cleared the flag first, no request follows.
- R7: The 3-bit sensitivity code per source selects 0 = rising edge, 1 = falling edge, 2 = either edge, 3 = high level and 4 = low level. Codes 5 to 7 never trigger.
- R8: A one written on a source's clear input clears its flag at the next clock edge. If a trigger occurs in that same cycle, the flag stays set.
- R9: An acknowledge while the request is high pushes the delivered level onto the active-level stack. From then until a return pulse pops it, no request of the same or a lower level is raised. A return pops the high entry first and then the low one.
- R10: When several deliverable sources of the winning level are pending, the request is raised and the source index names the lowest-numbered one.
- R11: A change on a source input is synchronized through two flops, so an edge or level trigger sets the flag on the third rising clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NSRC | Raw, asynchronous source inputs |
| sense_cfg | input | 3*NSRC | Sensitivity code per source, 3 bits each, source 0 in the low bits |
| src_en | input | NSRC | Per-source enables |
| src_hi | input | NSRC | Per-source priority bit (1 = high) |
| glb_en | input | 1 | Global delivery enable |
| flag_clr | input | NSRC | Write-one-to-clear strobes for the pending flags |
| flag_q | output | NSRC | Pending flags |
| req | output | 1 | Vectored interrupt request to the core |
| req_vec | output | VEC_W | Vector address of the delivered level |
| req_src | output | SRC_W | Lowest-numbered pending source of the delivered level |
| ack | input | 1 | Handler entry acknowledge from the core |
| reti | input | 1 | Handler return pulse from the core |
| lvl_act | output | 2 | Active levels: bit 1 high handler, bit 0 low handler |

## Verification
A software clear and a fresh trigger of the same source can land in one cycle. The bench provokes this by holding a level-sensitive input active while it strobes the clear, and it expects the flag to read one afterwards. Preemption and its forbidden reverse are also judged in a single sequence. A low handler is acknowledged, then a high one. The request is expected to rise for the high source and to stay low for the low source while both levels are active. Each return pulse must then peel off exactly the top stack entry.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int SENSE_W = 3;

    typedef enum logic [SENSE_W-1:0] {
        SNS_RISE = 3'd0,
        SNS_FALL = 3'd1,
        SNS_BOTH = 3'd2,
        SNS_HIGH = 3'd3,
        SNS_LOW  = 3'd4
    } sense_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } lvl_stack_t;

    localparam logic [7:0] VEC_HI_ADDR = 8'h08;
    localparam logic [7:0] VEC_LO_ADDR = 8'h18;

    function automatic logic trig_eval(input logic [SENSE_W-1:0] code,
                                       input logic cur, input logic prv);
        logic t;
        case (code)
            SNS_RISE: t = cur & ~prv;
            SNS_FALL: t = ~cur & prv;
            SNS_BOTH: t = cur ^ prv;
            SNS_HIGH: t = cur;
            SNS_LOW:  t = ~cur;
            default:  t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         cur,
    input  logic [NSRC-1:0]         prv,
    input  logic [SENSE_W*NSRC-1:0] sense,
    input  logic [NSRC-1:0]         clr,
    output logic [NSRC-1:0]         flag
);
    logic [NSRC-1:0] trig;
    logic [NSRC-1:0] flag_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb trig[g] = trig_eval(sense[g*SENSE_W +: SENSE_W], cur[g], prv[g]);

        always_ff @(posedge clk) begin
            if (rst) flag_q[g] <= 1'b0;
            else     flag_q[g] <= (flag_q[g] & ~clr[g]) | trig[g];
        end

        // R1 / R8: a trigger always leaves the flag set, even against a clear
        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            trig[g] |=> flag_q[g]);
        // R8: clear without trigger empties the flag
        a_r8_clear: assert property (@(posedge clk) disable iff (rst)
            (clr[g] && !trig[g]) |=> !flag_q[g]);
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int VEC_W = 8,
    parameter int SRC_W = 2
) (
    input  logic [NSRC-1:0]  flag,
    input  logic [NSRC-1:0]  src_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic             glb_en,
    input  lvl_stack_t       act,
    output logic             req,
    output logic             req_is_hi,
    output logic [VEC_W-1:0] req_vec,
    output logic [SRC_W-1:0] req_src
);
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] cand_hi;
    logic [NSRC-1:0] cand_lo;
    logic [NSRC-1:0] pick;
    logic            go_hi;
    logic            go_lo;

    always_comb begin
        elig    = flag & src_en & {NSRC{glb_en}};
        cand_hi = elig & src_hi;
        cand_lo = elig & ~src_hi;
        go_hi   = (|cand_hi) & ~act.hi;
        go_lo   = (|cand_lo) & ~act.hi & ~act.lo;
        pick    = go_hi ? cand_hi : cand_lo;
        req_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick[i]) req_src = SRC_W'(i);
        end
    end

    assign req       = go_hi | go_lo;
    assign req_is_hi = go_hi;
    assign req_vec   = go_hi ? VEC_W'(VEC_HI_ADDR) : VEC_W'(VEC_LO_ADDR);
endmodule

// File: rtl/irq_nest.sv
module irq_nest
    import irq_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_hi,
    input  logic       reti,
    output lvl_stack_t act
);
    lvl_stack_t stk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '0;
        end else if (take) begin
            if (take_hi) stk_q.hi <= 1'b1;
            else         stk_q.lo <= 1'b1;
        end else if (reti) begin
            if (stk_q.hi) stk_q.hi <= 1'b0;
            else          stk_q.lo <= 1'b0;
        end
    end

    assign act = stk_q;

    // R9: return pops only the top entry
    a_r9_pop_top: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && stk_q.hi && stk_q.lo) |=> (stk_q.lo && !stk_q.hi));
    a_r9_pop_lo: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && !stk_q.hi) |=> !stk_q.lo);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int VEC_W = 8,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NSRC-1:0]         irq_in,
    input  logic [SENSE_W*NSRC-1:0] sense_cfg,
    input  logic [NSRC-1:0]         src_en,
    input  logic [NSRC-1:0]         src_hi,
    input  logic                    glb_en,
    input  logic [NSRC-1:0]         flag_clr,
    output logic [NSRC-1:0]         flag_q,
    output logic                    req,
    output logic [VEC_W-1:0]        req_vec,
    output logic [SRC_W-1:0]        req_src,
    input  logic                    ack,
    input  logic                    reti,
    output logic [1:0]              lvl_act
);
    logic [NSRC-1:0] s_cur;
    logic [NSRC-1:0] s_prv;
    logic [NSRC-1:0] flags;
    lvl_stack_t      act;
    logic            req_w;
    logic            req_hi_w;

    irq_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst(rst), .raw(irq_in), .cur(s_cur), .prv(s_prv)
    );

    irq_detect #(.NSRC(NSRC)) u_det (
        .clk(clk), .rst(rst), .cur(s_cur), .prv(s_prv),
        .sense(sense_cfg), .clr(flag_clr), .flag(flags)
    );

    irq_arb #(.NSRC(NSRC), .VEC_W(VEC_W), .SRC_W(SRC_W)) u_arb (
        .flag(flags), .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en),
        .act(act), .req(req_w), .req_is_hi(req_hi_w),
        .req_vec(req_vec), .req_src(req_src)
    );

    irq_nest u_nest (
        .clk(clk), .rst(rst), .take(ack & req_w), .take_hi(req_hi_w),
        .reti(reti), .act(act)
    );

    assign flag_q  = flags;
    assign req     = req_w;
    assign lvl_act = {act.hi, act.lo};

    // R2: global enable gates delivery
    a_r2_glb_gate: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !req);
    // R5: low level never delivered over an active high handler
    a_r5_no_lo_over_hi: assert property (@(posedge clk) disable iff (rst)
        act.hi |-> !req);
    // R10 / R3: the reported source is pending and enabled
    a_r10_src_valid: assert property (@(posedge clk) disable iff (rst)
        req |-> (flags[req_src] && src_en[req_src]));
    // R4: delivered vector agrees with the reported source's priority
    a_r4_vec_prio: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_vec == (src_hi[req_src] ? VEC_W'(VEC_HI_ADDR) : VEC_W'(VEC_LO_ADDR))));
    // R9: an accepted high acknowledge marks the high level active
    a_r9_push_hi: assert property (@(posedge clk) disable iff (rst)
        (ack && req && req_vec == VEC_W'(VEC_HI_ADDR)) |=> act.hi);
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic [3*N-1:0] sense_cfg = '0;
    logic [N-1:0] src_en = '0;
    logic [N-1:0] src_hi = '0;
    logic         glb_en = 1'b0;
    logic [N-1:0] flag_clr = '0;
    logic [N-1:0] flag_q;
    logic         req;
    logic [7:0]   req_vec;
    logic [1:0]   req_src;
    logic         ack = 1'b0;
    logic         reti = 1'b0;
    logic [1:0]   lvl_act;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl #(.NSRC(N), .VEC_W(8)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sense_cfg(sense_cfg),
        .src_en(src_en), .src_hi(src_hi), .glb_en(glb_en), .flag_clr(flag_clr),
        .flag_q(flag_q), .req(req), .req_vec(req_vec), .req_src(req_src),
        .ack(ack), .reti(reti), .lvl_act(lvl_act)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr(input logic [N-1:0] m);
        flag_clr = m;
        step(1);
        flag_clr = '0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; step(1); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; step(1); reti = 1'b0;
    endtask

    // expected {req, vec, src} for the arbitration rules
    function automatic logic [12:0] model(input logic [N-1:0] f, input logic [N-1:0] en,
                                          input logic [N-1:0] hi, input logic g,
                                          input logic ah, input logic al);
        logic [N-1:0] e;
        logic [N-1:0] p;
        logic r;
        logic h;
        logic [3:0] s;
        e = f & en & {N{g}};
        h = (|(e & hi)) && !ah;
        r = h || ((|(e & ~hi)) && !ah && !al);
        p = h ? (e & hi) : (e & ~hi);
        s = 4'd0;
        for (int i = N - 1; i >= 0; i--) if (p[i]) s = 4'(i);
        if (!r) return 13'd0;
        return {1'b1, (h ? 8'h08 : 8'h18), s};
    endfunction

    task automatic chk_req(input string tag, input logic ah, input logic al);
        logic [12:0] m;
        m = model(flag_q, src_en, src_hi, glb_en, ah, al);
        chk({tag, " req"}, 32'(req), 32'(m[12]));
        if (m[12]) begin
            chk({tag, " vec"}, 32'(req_vec), 32'(m[11:4]));
            chk({tag, " src"}, 32'(req_src), 32'(m[3:0]));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // reset state
        chk("reset flags", 32'(flag_q), 0);
        chk("reset req", 32'(req), 0);
        chk("reset lvl", 32'(lvl_act), 0);

        // R7 / R11 rising edge on source 0, masked (R1)
        sense_cfg[2:0] = 3'd0;
        irq_in[0] = 1'b1;
        step(2);
        chk("R11 not yet", 32'(flag_q[0]), 0);
        step(1);
        chk("R11 third edge", 32'(flag_q[0]), 1);
        chk("R1 masked flag", 32'(flag_q[0]), 1);
        chk("R2 no req", 32'(req), 0);
        clr(4'b0001);
        chk("R8 clear", 32'(flag_q[0]), 0);
        irq_in[0] = 1'b0; step(3);
        chk("R7 rise ignores fall", 32'(flag_q[0]), 0);

        // falling edge
        irq_in[0] = 1'b1; sense_cfg[2:0] = 3'd1; step(3); clr(4'b0001);
        chk("R7 fall ignores rise", 32'(flag_q[0]), 0);
        irq_in[0] = 1'b0; step(3);
        chk("R7 fall", 32'(flag_q[0]), 1);
        clr(4'b0001);

        // either edge
        sense_cfg[2:0] = 3'd2;
        irq_in[0] = 1'b1; step(3);
        chk("R7 both rise", 32'(flag_q[0]), 1);
        clr(4'b0001);
        irq_in[0] = 1'b0; step(3);
        chk("R7 both fall", 32'(flag_q[0]), 1);
        clr(4'b0001);

        // high level; clear against a held trigger (R8 set wins)
        sense_cfg[2:0] = 3'd3;
        irq_in[0] = 1'b1; step(3);
        chk("R7 high", 32'(flag_q[0]), 1);
        clr(4'b0001);
        chk("R8 set wins high", 32'(flag_q[0]), 1);
        irq_in[0] = 1'b0; step(3); clr(4'b0001);
        chk("R7 high released", 32'(flag_q[0]), 0);

        // low level
        irq_in[0] = 1'b1; sense_cfg[2:0] = 3'd4; step(3); clr(4'b0001);
        chk("R7 low idle", 32'(flag_q[0]), 0);
        irq_in[0] = 1'b0; step(3);
        chk("R7 low", 32'(flag_q[0]), 1);
        clr(4'b0001);
        chk("R8 set wins low", 32'(flag_q[0]), 1);

        // unused code never triggers
        sense_cfg[2:0] = 3'd5; step(3); clr(4'b0001);
        irq_in[0] = 1'b1; step(3); irq_in[0] = 1'b0; step(3);
        chk("R7 code5 silent", 32'(flag_q[0]), 0);

        // R6 masked flag delivered on unmask
        sense_cfg = '0; step(3); clr('1);
        irq_in[1] = 1'b1; step(3);
        chk("R6 latched masked", 32'(flag_q[1]), 1);
        glb_en = 1'b1; step(1);
        chk("R3 source disabled", 32'(req), 0);
        src_en[1] = 1'b1; step(1);
        chk("R6 unmask req", 32'(req), 1);
        chk("R6 unmask src", 32'(req_src), 1);
        chk("R4 low vec", 32'(req_vec), 32'h18);
        src_en[1] = 1'b0; clr(4'b0010); src_en[1] = 1'b1; step(1);
        chk("R6 cleared first", 32'(req), 0);
        irq_in = '0; step(3); clr('1);

        // R5 / R9 nesting: src0 low, src1 high
        src_en = '1; src_hi = 4'b0010;
        irq_in[0] = 1'b1; step(3);
        chk("R4 lo vec", 32'(req_vec), 32'h18);
        chk("R10 lo src", 32'(req_src), 0);
        pulse_ack();
        chk("R9 push lo", 32'(lvl_act), 32'b01);
        chk("R9 same level held", 32'(req), 0);
        chk("R9 flag persists", 32'(flag_q[0]), 1);
        irq_in[1] = 1'b1; step(3);
        chk("R5 preempt req", 32'(req), 1);
        chk("R4 hi vec", 32'(req_vec), 32'h08);
        chk("R5 preempt src", 32'(req_src), 1);
        pulse_ack();
        chk("R9 push hi", 32'(lvl_act), 32'b11);
        clr(4'b0010);
        chk("R5 lo under hi", 32'(req), 0);
        pulse_reti();
        chk("R9 pop hi", 32'(lvl_act), 32'b01);
        chk("R9 lo still held", 32'(req), 0);
        pulse_reti();
        chk("R9 pop lo", 32'(lvl_act), 32'b00);
        chk("R9 lo redelivered", 32'(req), 1);
        chk("R9 lo vec", 32'(req_vec), 32'h18);
        pulse_reti();
        chk("R9 empty pop", 32'(lvl_act), 32'b00);

        // R10 lowest index among high sources, R3 masking shifts it
        irq_in = '0; step(3); clr('1);
        src_hi = '1;
        irq_in[3:2] = 2'b11; step(3);
        chk("R10 lowest", 32'(req_src), 2);
        src_en[2] = 1'b0; step(1);
        chk("R3 masked skip", 32'(req_src), 3);
        glb_en = 1'b0; step(1);
        chk("R2 global off", 32'(req), 0);

        // random mix with high-level sensitivity
        void'($urandom(32'd1357));
        sense_cfg = {N{3'd3}};
        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] pat;
            irq_in = '0; step(3); clr('1);
            pat = N'($urandom);
            irq_in = pat;
            src_en = N'($urandom);
            src_hi = N'($urandom);
            glb_en = 1'($urandom);
            step(3);
            chk("R1 random flags", 32'(flag_q), 32'(pat));
            chk_req("R10 random", 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule